// File: doc/BRIEF.md
# Backplane Frame Pulse Monitor

This block watches a backplane clock and an external frame synchronisation pulse, both already in the local clock domain. It finds the edges of the backplane clock, samples the frame pulse on the edge that configuration selects, and emits a one-cycle frame-start strobe on the first sampling edge of each pulse. It also emits a per-bit data-update enable on the selected update edge. When the backplane clock runs at twice the bit rate, each bit holds two update edges, and a configuration bit picks which of the two drives the enable.

The block also checks the frame grid. It counts bit periods from one frame pulse to the next. A pulse whose distance from the previous one is not a whole number of frames, or that lands in the middle of a bit at double rate, sets a sticky change indicator. That indicator raises the interrupt output when the interrupt enable is set. A write-one-to-clear input resets the indicator.

Top module: `frame_pulse_monitor`

## Requirements
- R1: While reset is active and after it is released, with no backplane clock edge, frm_start_o, dat_upd_o, chg_ind_o and irq_o are all 0.
- R2: The frame pulse is active high when cfg_fp_inv_i is 0 and active low when it is 1.
- R3: The frame pulse is sampled on rising edges of bck_i when cfg_fp_fall_i is 0 and on falling edges when it is 1. frm_start_o is high for one clock, in the clock after the one in which that edge is seen.
- R4: A pulse that stays active over several sampling edges gives a single frm_start_o, on its first sampling edge.
- R5: With cfg_dbl_i = 0 (one backplane cycle per bit), dat_upd_o is high for one clock after every update edge: rising if cfg_dat_fall_i = 0, falling if it is 1.
- R6: With cfg_dbl_i = 1 (two backplane cycles per bit), update edges alternate phase 0 and phase 1. Phase 0 is the first update edge at or after the frame pulse sampling edge. dat_upd_o follows only the edges whose phase equals cfg_upd_2nd_i.
- R7: A detected pulse sets chg_ind_o in the same cycle as its frm_start_o in either of two cases: the number of bits since the previous pulse is not a multiple of FRAME_BITS, or, at double rate, the pulse is first sampled on the second backplane cycle of a bit.
- R8: The first pulse after reset only sets the reference and never sets chg_ind_o.
- R9: chg_ind_o stays set until a clock in which clr_i is 1; it reads 0 after that clock unless a new error is detected at the same time.
- R10: irq_o equals chg_ind_o when cfg_irq_en_i is 1 and stays 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, faster than the backplane clock edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bck_i | input | 1 | Backplane clock level, synchronous to clk |
| fp_i | input | 1 | Frame synchronisation pulse |
| cfg_fp_inv_i | input | 1 | 1: frame pulse active low |
| cfg_fp_fall_i | input | 1 | 1: sample the pulse on the falling backplane edge |
| cfg_dat_fall_i | input | 1 | 1: update data on the falling backplane edge |
| cfg_dbl_i | input | 1 | 1: backplane clock at twice the bit rate |
| cfg_upd_2nd_i | input | 1 | At double rate, 1 selects the second update edge of each bit |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Write-one-to-clear for the change indicator |
| frm_start_o | output | 1 | One-clock frame-start strobe |
| dat_upd_o | output | 1 | One-clock data-update enable |
| chg_ind_o | output | 1 | Sticky frame spacing error indicator |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with FRAME_BITS = 8. With that value, frames that land on the grid, off it, and two frames apart take only a few dozen backplane cycles. This makes it possible to sweep every combination of rate, sampling edge, update edge, update phase and polarity, each with several pulse spacings. The spacing check and the position of the update enable within a bit are predicted by arithmetic on those settings.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } fpm_edge_e;

  // pick one of the two detected backplane edges
  function automatic logic fpm_pick_edge(input fpm_edge_e sel,
                                         input logic rise,
                                         input logic fall);
    return (sel == EDGE_FALL) ? fall : rise;
  endfunction

endpackage

// File: rtl/fpm_edge_sel.sv
module fpm_edge_sel
  import fpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bck_i,
  input  logic fp_i,
  input  logic fp_inv,
  input  logic fp_fall,
  input  logic dat_fall,
  output logic smp_edge,
  output logic dat_edge,
  output logic fp_det
);

  logic bck_q, bck_d;
  logic fp_prev_q, fp_prev_d;
  logic rise, fall, fp_act;

  always_comb begin
    rise      = bck_i & ~bck_q;
    fall      = ~bck_i & bck_q;
    fp_act    = fp_i ^ fp_inv;
    smp_edge  = fpm_pick_edge(fpm_edge_e'(fp_fall), rise, fall);
    dat_edge  = fpm_pick_edge(fpm_edge_e'(dat_fall), rise, fall);
    // only the first sampling edge of an active pulse counts
    fp_det    = smp_edge & fp_act & ~fp_prev_q;
    bck_d     = bck_i;
    fp_prev_d = smp_edge ? fp_act : fp_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q     <= 1'b0;
      fp_prev_q <= 1'b0;
    end else begin
      bck_q     <= bck_d;
      fp_prev_q <= fp_prev_d;
    end
  end

endmodule

// File: rtl/fpm_spacing.sv
module fpm_spacing #(
  parameter int FRAME_BITS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_edge,
  input  logic fp_det,
  input  logic dbl,
  input  logic clr,
  output logic chg_q
);

  localparam int CW = $clog2(FRAME_BITS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;
  logic          armed_q, armed_d;
  logic          chg_d, err;

  always_comb begin
    cnt_d   = cnt_q;
    half_d  = half_q;
    armed_d = armed_q;
    err     = 1'b0;
    if (fp_det) begin
      err     = armed_q & ((dbl & half_q) | (cnt_q != {CW{1'b1}}));
      cnt_d   = '0;
      half_d  = dbl;
      armed_d = 1'b1;
    end else if (smp_edge) begin
      if (dbl & half_q) begin
        half_d = 1'b0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        half_d = dbl;
      end
    end
    chg_d = err | (chg_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      half_q  <= 1'b0;
      armed_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      armed_q <= armed_d;
      chg_q   <= chg_d;
    end
  end

endmodule

// File: rtl/fpm_dphase.sv
module fpm_dphase (
  input  logic clk,
  input  logic rst_n,
  input  logic dat_edge,
  input  logic fp_det,
  input  logic dbl,
  input  logic upd_2nd,
  output logic upd
);

  logic dph_q, dph_d, cur;

  always_comb begin
    cur   = fp_det ? 1'b0 : dph_q;
    dph_d = dph_q;
    if (dat_edge) begin
      dph_d = ~cur;
    end else if (fp_det) begin
      dph_d = 1'b0;
    end
    upd = dat_edge & (~dbl | (cur == upd_2nd));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_q <= 1'b0;
    end else begin
      dph_q <= dph_d;
    end
  end

endmodule

// File: rtl/frame_pulse_monitor.sv
module frame_pulse_monitor #(
  parameter int FRAME_BITS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_i,
  input  logic fp_i,
  input  logic cfg_fp_inv_i,
  input  logic cfg_fp_fall_i,
  input  logic cfg_dat_fall_i,
  input  logic cfg_dbl_i,
  input  logic cfg_upd_2nd_i,
  input  logic cfg_irq_en_i,
  input  logic clr_i,
  output logic frm_start_o,
  output logic dat_upd_o,
  output logic chg_ind_o,
  output logic irq_o
);

  logic rst_meta_q, rst_sync_q;
  logic smp_edge, dat_edge, fp_det, upd;
  logic frm_q, frm_d, upd_q, upd_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  fpm_edge_sel edge_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .bck_i    (bck_i),
    .fp_i     (fp_i),
    .fp_inv   (cfg_fp_inv_i),
    .fp_fall  (cfg_fp_fall_i),
    .dat_fall (cfg_dat_fall_i),
    .smp_edge (smp_edge),
    .dat_edge (dat_edge),
    .fp_det   (fp_det)
  );

  fpm_spacing #(.FRAME_BITS(FRAME_BITS)) spc_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .smp_edge (smp_edge),
    .fp_det   (fp_det),
    .dbl      (cfg_dbl_i),
    .clr      (clr_i),
    .chg_q    (chg_ind_o)
  );

  fpm_dphase dph_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .dat_edge (dat_edge),
    .fp_det   (fp_det),
    .dbl      (cfg_dbl_i),
    .upd_2nd  (cfg_upd_2nd_i),
    .upd      (upd)
  );

  always_comb begin
    frm_d = fp_det;
    upd_d = upd;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      frm_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      frm_q <= frm_d;
      upd_q <= upd_d;
    end
  end

  assign frm_start_o = frm_q;
  assign dat_upd_o   = upd_q;
  assign irq_o       = chg_ind_o & cfg_irq_en_i;

endmodule

// File: rtl/frame_pulse_monitor_chk.sv
module frame_pulse_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_dbl_i,
  input logic cfg_irq_en_i,
  input logic clr_i,
  input logic frm_start_o,
  input logic dat_upd_o,
  input logic chg_ind_o,
  input logic irq_o
);

  // R4: one strobe per pulse, never two cycles in a row
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o |=> !frm_start_o);

  // R5: single-rate update enable is a one-clock pulse
  a_r5_upd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dbl_i && dat_upd_o) |=> !dat_upd_o);

  // R7: the indicator rises only together with a frame strobe
  a_r7_rise_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_ind_o) |-> frm_start_o);

  // R9: sticky while not cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_ind_o && !clr_i) |=> chg_ind_o);

  // R9: clear works unless a new error lands at once
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!chg_ind_o || frm_start_o));

  // R10: interrupt silent while disabled
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en_i |-> !irq_o);

endmodule

bind frame_pulse_monitor frame_pulse_monitor_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_dbl_i    (cfg_dbl_i),
  .cfg_irq_en_i (cfg_irq_en_i),
  .clr_i        (clr_i),
  .frm_start_o  (frm_start_o),
  .dat_upd_o    (dat_upd_o),
  .chg_ind_o    (chg_ind_o),
  .irq_o        (irq_o)
);

// File: tb/frame_pulse_monitor_tb_top.sv
module frame_pulse_monitor_tb_top;

  localparam int CLK_P = 10;
  localparam int FB    = 8;

  logic clk = 1'b0;
  logic rst_n, bck, fp, inv, fe, de, dbl, upd2, irq_en, clr;
  logic fs, du, ind, irq;

  int n_chk = 0, n_bad = 0;
  int fs_cnt, du_cnt, du_mask;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_pulse_monitor #(.FRAME_BITS(FB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bck_i(bck), .fp_i(fp),
    .cfg_fp_inv_i(inv), .cfg_fp_fall_i(fe), .cfg_dat_fall_i(de),
    .cfg_dbl_i(dbl), .cfg_upd_2nd_i(upd2), .cfg_irq_en_i(irq_en),
    .clr_i(clr), .frm_start_o(fs), .dat_upd_o(du), .chg_ind_o(ind),
    .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bck = 1'b0; fp = inv; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fs_cnt = 0; du_cnt = 0; du_mask = 0;
  endtask

  task automatic half(input logic b, input logic act, input int idx);
    @(negedge clk);
    bck = b; fp = act ^ inv;
    @(posedge clk); #1;
    if (fs) fs_cnt++;
    if (du) begin du_cnt++; du_mask |= (1 << idx); end
  endtask

  task automatic do_bit(input logic a0, input logic a1);
    half(1'b1, a0, 0); half(1'b0, a0, 1);
    if (dbl) begin half(1'b1, a1, 2); half(1'b0, a1, 3); end
  endtask

  task automatic scen(input int d);
    int idx;
    do_reset();
    do_bit(1, 1);
    du_cnt = 0; du_mask = 0;
    for (int i = 0; i < d - 1; i++) do_bit(0, 0);
    do_bit(1, 1);
    if (!dbl) idx = de;
    else if (fe && !de) idx = upd2 ? 0 : 2;
    else idx = de + 2 * upd2;
    check("R2/R3 frame strobes", fs_cnt, 2);
    check("R7 spacing flag", ind, (d % FB) != 0);
    check("R10 irq follows flag", irq, ind);
    check(dbl ? "R6 update count" : "R5 update count", du_cnt, d);
    check(dbl ? "R6 update edge" : "R5 update edge", du_mask, 1 << idx);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    inv = 0; fe = 0; de = 0; dbl = 0; upd2 = 0; irq_en = 1; clr = 0;
    rst_n = 0; bck = 0; fp = 0;
    repeat (2) @(negedge clk);
    check("R1 reset frame", fs, 0);
    check("R1 reset ind", ind, 0);
    do_reset();
    check("R1 after reset upd", du, 0);
    check("R1 after reset irq", irq, 0);

    // sweep of all configurations and spacings
    for (int c = 0; c < 32; c++) begin
      {dbl, fe, de, upd2, inv} = 5'(c);
      scen(5); scen(8); scen(16);
    end

    // R8: first pulse only sets the reference
    dbl = 0; fe = 0; de = 0; inv = 0;
    do_reset();
    do_bit(0, 0); do_bit(0, 0); do_bit(1, 1); do_bit(0, 0);
    check("R8 first pulse strobe", fs_cnt, 1);
    check("R8 first pulse unflagged", ind, 0);

    // R4: long pulse counts once from its first edge
    do_reset();
    do_bit(1, 1); do_bit(1, 1); do_bit(1, 1);
    for (int i = 0; i < 5; i++) do_bit(0, 0);
    do_bit(1, 1);
    check("R4 long pulse strobes", fs_cnt, 2);
    check("R4 long pulse spacing", ind, 0);

    // R7: mid-bit pulse at double rate
    dbl = 1;
    do_reset();
    do_bit(1, 1);
    for (int i = 0; i < 7; i++) do_bit(0, 0);
    do_bit(0, 1);
    check("R7 mid-bit strobe", fs_cnt, 2);
    check("R7 mid-bit flag", ind, 1);

    // R10: gated interrupt
    irq_en = 0;
    @(negedge clk); #1;
    check("R10 disabled irq", irq, 0);
    irq_en = 1;
    @(negedge clk); #1;
    check("R10 enabled irq", irq, 1);

    // R9: sticky then cleared
    do_bit(0, 0);
    check("R9 sticky", ind, 1);
    @(negedge clk); clr = 1;
    @(posedge clk); #1;
    check("R9 cleared", ind, 0);
    @(negedge clk); clr = 0;
    do_bit(0, 0);
    check("R9 stays clear", ind, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule